// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and keeps its contents alive afterwards. Once reset is released it holds every strobe inactive for a programmable pause, then runs a fixed number of warm-up refresh cycles. After that it raises `ready_o` and hands refresh over to a periodic scheme. The access sequencer keeps normal ownership of the memory pins.

An interval timer adds one owed refresh each time it expires. While at least one refresh is owed, the block asks the access sequencer for the pins with a request/grant handshake. A refresh starts only when the grant is present. The owed count saturates at a parameterized ceiling, and at that ceiling an urgency flag tells the sequencer to stop holding an open page.

Two refresh methods are offered, chosen per cycle by a mode input:
- Column-strobe-first refresh: the row counter is inside the memory.
- Row-only refresh: a local 9-bit row counter is placed on the address pins.

Warm-up cycles use whichever method is selected.

All timing is given in clock cycles. At 50 MHz the defaults are a 200 µs pause, a 15.6 µs refresh interval, and 512 refreshes within 8 ms.

Top module: `dram_refresh_seq`

## Requirements
- R1: For the first PAUSE_CYC clock cycles after reset release, `ras_n_o` and every `cas_n_o` bit are 1, `addr_oe_o` is 0 and `ready_o` is 0.
- R2: After the pause, exactly WARM_CYCLES refresh cycles are issued without any request. `ready_o` rises on the clock edge that ends the last of them and stays 1. `ref_req_o` is never 1 while `ready_o` is 0.
- R3: In column-strobe-first mode (`ras_only_i`=0), all `cas_n_o` bits go to 0 for SETUP_CYC cycles before `ras_n_o` goes to 0. `ras_n_o` then stays 0 for RAS_LOW_CYC cycles with `cas_n_o` held at 0, and both return to 1 together. `addr_oe_o` stays 0 throughout.
- R4: In row-only mode (`ras_only_i`=1), `cas_n_o` stays all ones. `addr_oe_o` is 1 and `addr_o` carries the row counter for SETUP_CYC cycles before, and the RAS_LOW_CYC cycles during, the low pulse of `ras_n_o`. `addr_o` is 0 whenever `addr_oe_o` is 0.
- R5: After each low pulse, `ras_n_o` stays 1 for at least PRE_CYC+1 cycles before it can fall again.
- R6: Once ready, one refresh becomes owed every INTERVAL_CYC cycles. The first falls INTERVAL_CYC cycles after `ready_o` rises. With a grant always present, the number of refresh cycles in a window equals the number of intervals it spans.
- R7: `ref_req_o` is 1 when ready and either a refresh is owed or a refresh cycle is in progress. A refresh starts only on a clock where `ref_gnt_i` is 1. With `ref_gnt_i` at 0, no strobe activity occurs.
- R8: The owed count never exceeds PEND_MAX, and a new owed refresh at the ceiling is dropped. `ref_urgent_o` is 1 exactly when the count equals PEND_MAX.
- R9: The row counter is 0 after reset. It advances by one after each row-only cycle, including warm-up cycles, and wraps from 511 to 0.
- R10: The refresh method is sampled from `ras_only_i` when each refresh cycle starts. A change of mode therefore takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | Refresh method: 1 = row-only, 0 = column-strobe-first |
| ref_gnt_i | input | 1 | Pins granted by the access sequencer |
| ref_req_o | output | 1 | Refresh wants the pins |
| ref_urgent_o | output | 1 | Owed count at its ceiling |
| ready_o | output | 1 | Initialization complete |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | N_CAS | Column strobes, active low, one per byte lane |
| addr_o | output | ROW_W | Refresh row address |
| addr_oe_o | output | 1 | Block drives the address pins |

## Verification
The refresh engine is driven under four grant and mode patterns:
- Grant always present in column-strobe-first mode: shows that the refresh count matches the interval rate.
- Grant withheld over many intervals: separates a correct saturating owed count, with urgency raised, from an overflowing count or from refreshes that ignore the grant.
- Release of a withheld grant: shows that the backlog drains back to back, honouring precharge spacing.
- Mode switch, then a long row-only run past 512 cycles: shows per-cycle sampling of the method and the wrap of the row counter.

A cycle-level behavioural model also checks the exact ready cycle after the pause and the warm-up.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {INIT_PAUSE, INIT_WARM, INIT_RUN} init_e;
  typedef enum logic [1:0] {CYC_IDLE, CYC_SETUP, CYC_ACT, CYC_PRE} cyc_e;
endpackage

// File: rtl/rfs_interval_tmr.sv
module rfs_interval_tmr #(
  parameter int unsigned INTERVAL_CYC = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned TW = $clog2(INTERVAL_CYC + 1);

  logic [TW-1:0] tmr_q;

  assign tick_o = en_i && (tmr_q == TW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tmr_q <= '0;
    else if (!en_i || tick_o) tmr_q <= '0;
    else                    tmr_q <= tmr_q + 1'b1;
  end

  assert_tick_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
  parameter int unsigned PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o,
  output logic full_o
);
  localparam int unsigned OW = $clog2(PEND_MAX + 1);

  logic [OW-1:0] owed_q;

  assign nz_o   = (owed_q != '0);
  assign full_o = (owed_q == OW'(PEND_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (!full_o) owed_q <= owed_q + 1'b1;
        2'b01:   if (nz_o)    owed_q <= owed_q - 1'b1;
        default: ;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= OW'(PEND_MAX));
  assert_saturate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && inc_i && !dec_i) |=> full_o);
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  assign row_o = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + 1'b1;
  end

  assert_row_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (row_q == '1)) |=> (row_q == '0));
endmodule

// File: rtl/rfs_cycle_gen.sv
module rfs_cycle_gen
  import rfs_pkg::*;
#(
  parameter int unsigned N_CAS       = 4,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned RAS_LOW_CYC = 3,
  parameter int unsigned PRE_CYC     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ras_only_i,
  output logic             idle_o,
  output logic             done_o,
  output logic             ras_only_o,
  output logic             ras_n_o,
  output logic [N_CAS-1:0] cas_n_o,
  output logic             addr_oe_o
);
  localparam int unsigned M1     = (SETUP_CYC > RAS_LOW_CYC) ? SETUP_CYC : RAS_LOW_CYC;
  localparam int unsigned CNT_MX = (M1 > PRE_CYC) ? M1 : PRE_CYC;
  localparam int unsigned CW     = $clog2(CNT_MX + 1);

  cyc_e          st_q;
  logic [CW-1:0] cnt_q;
  logic          mode_q;
  logic          strobe_ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CYC_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (st_q)
        CYC_IDLE: if (start_i) begin
          st_q   <= CYC_SETUP;
          cnt_q  <= CW'(SETUP_CYC - 1);
          mode_q <= ras_only_i;
        end
        CYC_SETUP: if (cnt_q == '0) begin
          st_q  <= CYC_ACT;
          cnt_q <= CW'(RAS_LOW_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        CYC_ACT: if (cnt_q == '0) begin
          st_q  <= CYC_PRE;
          cnt_q <= CW'(PRE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        CYC_PRE: if (cnt_q == '0) st_q <= CYC_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: st_q <= CYC_IDLE;
      endcase
    end
  end

  assign strobe_ph  = (st_q == CYC_SETUP) || (st_q == CYC_ACT);
  assign idle_o     = (st_q == CYC_IDLE);
  assign done_o     = (st_q == CYC_PRE) && (cnt_q == '0);
  assign ras_only_o = mode_q;
  assign ras_n_o    = (st_q != CYC_ACT);
  assign addr_oe_o  = mode_q && strobe_ph;

  for (genvar g = 0; g < N_CAS; g++) begin : g_lane
    assign cas_n_o[g] = !(!mode_q && strobe_ph);
  end

  // pulse-width monitors for the strobe timing checks
  logic [CW-1:0] hi_run_q, lo_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= CW'(PRE_CYC);
      lo_run_q <= '0;
    end else begin
      if (!ras_n_o)                    hi_run_q <= '0;
      else if (hi_run_q != CW'(PRE_CYC)) hi_run_q <= hi_run_q + 1'b1;
      if (ras_n_o)                     lo_run_q <= '0;
      else if (lo_run_q != CW'(RAS_LOW_CYC)) lo_run_q <= lo_run_q + 1'b1;
    end
  end

  assert_cas_before_ras_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !mode_q) |-> ((cas_n_o == '0) && ($past(cas_n_o) == '0)));
  assert_ras_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_run_q == CW'(RAS_LOW_CYC)));
  assert_ras_only_cas_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !idle_o) |-> (cas_n_o == '1));
  assert_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_run_q == CW'(PRE_CYC)));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 10000,
  parameter int unsigned WARM_CYCLES  = 8,
  parameter int unsigned INTERVAL_CYC = 780,
  parameter int unsigned SETUP_CYC    = 1,
  parameter int unsigned RAS_LOW_CYC  = 3,
  parameter int unsigned PRE_CYC      = 2,
  parameter int unsigned PEND_MAX     = 8,
  parameter int unsigned ROW_W        = 9,
  parameter int unsigned N_CAS        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             ref_gnt_i,
  output logic             ref_req_o,
  output logic             ref_urgent_o,
  output logic             ready_o,
  output logic             ras_n_o,
  output logic [N_CAS-1:0] cas_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             addr_oe_o
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned WW = $clog2(WARM_CYCLES + 1);

  init_e            init_q;
  logic [PW-1:0]    pause_q;
  logic [WW-1:0]    warm_q;
  logic             gen_start, gen_idle, gen_done, gen_mode;
  logic             tick, owed_nz, owed_full;
  logic [ROW_W-1:0] row;

  assign ready_o   = (init_q == INIT_RUN);
  assign gen_start = gen_idle &&
                     ((init_q == INIT_WARM) || (ready_o && owed_nz && ref_gnt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= INIT_PAUSE;
      pause_q <= '0;
      warm_q  <= '0;
    end else begin
      unique case (init_q)
        INIT_PAUSE: if (pause_q == PW'(PAUSE_CYC - 1)) init_q <= INIT_WARM;
                    else pause_q <= pause_q + 1'b1;
        INIT_WARM: if (gen_done) begin
          if (warm_q == WW'(WARM_CYCLES - 1)) init_q <= INIT_RUN;
          warm_q <= warm_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  rfs_interval_tmr #(.INTERVAL_CYC(INTERVAL_CYC)) u_tmr (
    .clk_i, .rst_ni, .en_i(ready_o), .tick_o(tick)
  );

  rfs_owed_ctr #(.PEND_MAX(PEND_MAX)) u_owed (
    .clk_i, .rst_ni, .inc_i(tick), .dec_i(gen_done && ready_o),
    .nz_o(owed_nz), .full_o(owed_full)
  );

  rfs_cycle_gen #(
    .N_CAS(N_CAS), .SETUP_CYC(SETUP_CYC), .RAS_LOW_CYC(RAS_LOW_CYC), .PRE_CYC(PRE_CYC)
  ) u_gen (
    .clk_i, .rst_ni, .start_i(gen_start), .ras_only_i,
    .idle_o(gen_idle), .done_o(gen_done), .ras_only_o(gen_mode),
    .ras_n_o, .cas_n_o, .addr_oe_o
  );

  rfs_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni, .adv_i(gen_done && gen_mode), .row_o(row)
  );

  assign addr_o       = addr_oe_o ? row : '0;
  assign ref_req_o    = ready_o && (owed_nz || !gen_idle);
  assign ref_urgent_o = owed_full;

  assert_quiet_pause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q == INIT_PAUSE) |-> (ras_n_o && (cas_n_o == '1) && !addr_oe_o));
  assert_no_req_early_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !ref_req_o);
  assert_start_on_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ready_o) && $past(gen_idle) && !gen_idle) |-> $past(ref_gnt_i));
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int unsigned PAUSE = 100, WARM = 8, INTV = 60, SETC = 1, RLOW = 3, PREC = 2;
  localparam int unsigned PMAX = 8, RW = 9, NC = 4;
  localparam int unsigned CYC_LEN = SETC + RLOW + PREC + 1;

  logic clk = 1'b0, rst_n = 1'b0, ras_only = 1'b0, gnt = 1'b0;
  logic ref_req, ref_urgent, ready, ras_n, addr_oe;
  logic [NC-1:0] cas_n;
  logic [RW-1:0] addr;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .WARM_CYCLES(WARM), .INTERVAL_CYC(INTV), .SETUP_CYC(SETC),
    .RAS_LOW_CYC(RLOW), .PRE_CYC(PREC), .PEND_MAX(PMAX), .ROW_W(RW), .N_CAS(NC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_only_i(ras_only), .ref_gnt_i(gnt),
    .ref_req_o(ref_req), .ref_urgent_o(ref_urgent), .ready_o(ready),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .addr_o(addr), .addr_oe_o(addr_oe)
  );

  int checks = 0, errors = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 pause, 1 warm-up, 2 running; cycle 0 idle,1 setup,2 low,3 precharge
  int m_ph, m_pc, m_wc, m_tmr, m_owe, m_cs, m_cc, m_mode, m_row;
  bit m_done, m_tick, m_start;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = 0; m_wc = 0; m_tmr = 0; m_owe = 0;
      m_cs = 0; m_cc = 0; m_mode = 0; m_row = 0;
    end else begin
      m_done  = (m_cs == 3) && (m_cc == 0);
      m_tick  = (m_ph == 2) && (m_tmr == INTV - 1);
      m_start = (m_cs == 0) && ((m_ph == 1) || ((m_ph == 2) && (m_owe > 0) && gnt));
      if (m_ph == 2) begin
        if (m_tick && !m_done && m_owe < PMAX) m_owe++;
        else if (m_done && !m_tick && m_owe > 0) m_owe--;
      end
      m_tmr = (m_ph != 2 || m_tick) ? 0 : m_tmr + 1;
      if (m_done && m_mode != 0) m_row = (m_row + 1) % 512;
      case (m_cs)
        0: if (m_start) begin m_cs = 1; m_cc = SETC - 1; m_mode = int'(ras_only); end
        1: if (m_cc == 0) begin m_cs = 2; m_cc = RLOW - 1; end else m_cc--;
        2: if (m_cc == 0) begin m_cs = 3; m_cc = PREC - 1; end else m_cc--;
        default: if (m_cc == 0) m_cs = 0; else m_cc--;
      endcase
      if (m_ph == 0) begin
        if (m_pc == PAUSE - 1) m_ph = 1; else m_pc++;
      end else if (m_ph == 1 && m_done) begin
        if (m_wc == WARM - 1) m_ph = 2;
        m_wc++;
      end
    end
  end

  // per-cycle comparison and event counters, sampled at the falling edge
  int cyc_cnt, pause_ev, falls, warm_falls, f_cbr, f_ro, high_run, gap_viol, ro_idx, first_ready;
  bit prev_ras, seen_max, seen_wrap;
  bit e_act, e_ras, e_oe;
  logic [NC-1:0] e_cas;
  logic [RW-1:0] e_addr;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc_cnt = 0; pause_ev = 0; falls = 0; warm_falls = 0; f_cbr = 0; f_ro = 0;
      high_run = 100; gap_viol = 0; ro_idx = 0; first_ready = -1;
      prev_ras = 1'b1; seen_max = 1'b0; seen_wrap = 1'b0;
    end else if (!fin) begin
      cyc_cnt++;
      e_act  = (m_cs == 1) || (m_cs == 2);
      e_ras  = (m_cs != 2);
      e_cas  = (m_mode == 0 && e_act) ? '0 : '1;
      e_oe   = (m_mode != 0) && e_act;
      e_addr = e_oe ? RW'(m_row) : '0;
      chk({ras_n, cas_n} === {e_ras, e_cas}, "R3 strobe pattern", int'({ras_n, cas_n}), int'({e_ras, e_cas}));
      chk({addr_oe, addr} === {e_oe, e_addr}, "R4 address drive", int'({addr_oe, addr}), int'({e_oe, e_addr}));
      chk(ready === (m_ph == 2), "R2 ready", int'(ready), int'(m_ph == 2));
      chk(ref_req === ((m_ph == 2) && (m_owe > 0 || m_cs != 0)), "R7 request", int'(ref_req),
          int'((m_ph == 2) && (m_owe > 0 || m_cs != 0)));
      chk(ref_urgent === (m_owe == PMAX), "R8 urgent", int'(ref_urgent), int'(m_owe == PMAX));
      if (cyc_cnt <= PAUSE && (!ras_n || cas_n != '1 || addr_oe || ready)) pause_ev++;
      if (ready && first_ready < 0) first_ready = cyc_cnt;
      if (prev_ras && !ras_n) begin
        falls++;
        if (!ready) warm_falls++;
        if (cas_n == '0) f_cbr++;
        else if (cas_n == '1) f_ro++;
        if (high_run < PREC + 1) gap_viol++;
        if (addr_oe) begin
          chk(addr == RW'(ro_idx % 512), "R9 row sequence", int'(addr), ro_idx % 512);
          if (addr == RW'(511)) seen_max = 1'b1;
          if (addr == '0 && seen_max) seen_wrap = 1'b1;
          ro_idx++;
        end
      end
      high_run = ras_n ? high_run + 1 : 0;
      prev_ras = ras_n;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0;
    ras_only = mode;
    gnt = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    #1;
    chk(!ready && ras_n && cas_n == '1 && !addr_oe && !ref_req, "R1 reset state",
        int'({ready, ras_n, cas_n, addr_oe, ref_req}), int'({1'b0, 1'b1, {NC{1'b1}}, 2'b00}));
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !ready; i++) wait_cyc(1);
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  int base, base2;
  initial begin
    // column-strobe-first run
    do_reset(1'b0);
    wait_ready();
    chk(pause_ev == 0, "R1 quiet pause", pause_ev, 0);
    chk(first_ready == int'(PAUSE + WARM * CYC_LEN), "R2 ready cycle", first_ready, PAUSE + WARM * CYC_LEN);
    chk(warm_falls == WARM, "R2 warm-up count", warm_falls, WARM);
    chk(f_cbr == WARM, "R3 warm-up type", f_cbr, WARM);
    base = falls;
    wait_cyc(10 * INTV + 10);
    chk(falls - base == 10, "R6 refresh rate", falls - base, 10);
    gnt = 1'b0;
    base = falls;
    wait_cyc(12 * INTV);
    chk(falls - base == 0, "R7 no refresh without grant", falls - base, 0);
    chk(ref_urgent == 1'b1, "R8 urgent at ceiling", int'(ref_urgent), 1);
    gnt = 1'b1;
    base = falls;
    wait_cyc(2 * INTV);
    chk(falls - base >= 8 && falls - base <= 10, "R8 backlog drain", falls - base, 9);
    chk(ref_urgent == 1'b0, "R8 urgent cleared", int'(ref_urgent), 0);
    ras_only = 1'b1;
    base2 = f_ro;
    wait_cyc(3 * INTV);
    chk(f_ro - base2 == 3, "R10 mode switch", f_ro - base2, 3);
    chk(gap_viol == 0, "R5 precharge gap", gap_viol, 0);
    // row-only run
    do_reset(1'b1);
    wait_ready();
    chk(pause_ev == 0, "R1 quiet pause row-only", pause_ev, 0);
    chk(warm_falls == WARM && f_ro == WARM, "R4 row-only warm-up", f_ro, WARM);
    wait_cyc(515 * INTV);
    chk(seen_wrap, "R9 row wrap", int'(seen_wrap), 1);
    chk(ro_idx >= 520, "R6 row-only rate", ro_idx, 523);
    chk(gap_viol == 0, "R5 precharge gap row-only", gap_viol, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end
endmodule